// File: doc/BRIEF.md
# Segmented Streaming Scan Unit

This block computes a running prefix combination over a stream of W-bit elements that arrive one per cycle in processor order. Each element carries a valid strobe, an active flag and a segment-start flag. For every valid element the block returns, one cycle later, the combination of the earlier active elements in the current segment. In inclusive mode the element itself is part of that combination. The operator is chosen from add, multiply, unsigned maximum, signed maximum, signed minimum, bitwise AND, bitwise OR and copy.

A second result runs beside the segmented scan. It ignores segment boundaries and folds every active element of the whole sequence together. When an element flagged as the end of the sequence is accepted, this total is presented for one cycle. The element that follows starts a new sequence from an empty state. Each partial combination is held as a value plus an "anything seen yet" flag. An empty state therefore reads as the operator's identity, even if the operator changes between sequences.

Top module: `seg_scan_unit`

## Requirements
- R1: In exclusive mode (`incl`=0) the output for an element is the combination of all strictly earlier active elements of its segment. The first element of a segment gets the operator identity. For example, add over 3 2 6 4 5 11 0 9 gives 0 3 5 11 15 20 31 31.
- R2: In inclusive mode (`incl`=1) the output also includes the element itself when it is active. The same add input gives 3 5 11 15 20 31 31 40.
- R3: A valid element with `in_seg_start`=1 discards the running segment value before it is combined. Each segment is scanned on its own.
- R4: An element with `in_active`=0 leaves the running value unchanged. Its output equals the current running value, or the identity if nothing has been seen.
- R5: The `op_sel` codes are 0 add, 1 multiply, 2 unsigned max, 3 signed max, 4 signed min, 5 AND, 6 OR and 7 copy. Their exclusive identities are 0, 1, 0, the most negative value, the most positive value, all ones, 0 and 0.
- R6: Add and multiply wrap modulo 2^W. Signed max and min treat the data as two's complement.
- R7: Copy gives the first active element of a segment to that element (inclusive mode only) and to every later element of the segment.
- R8: `out_valid` follows `in_valid` by exactly one cycle, and `out_data` is registered. Cycles with `in_valid`=0 change no state.
- R9: A valid element with `in_last`=1 raises `red_valid` on the next cycle. At that cycle `red_data` holds the combination of all active elements since the previous end of sequence, across all segments. The following element starts an empty sequence.
- R10: While `rst_n` is low, all outputs are 0 and all running state is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Operator code (see R5) |
| incl | input | 1 | 1 = inclusive scan, 0 = exclusive |
| in_valid | input | 1 | Element present this cycle |
| in_active | input | 1 | Element contributes to the scan |
| in_seg_start | input | 1 | Element opens a new segment |
| in_last | input | 1 | Element closes the sequence |
| in_data | input | W | Element value |
| out_valid | output | 1 | Scan result present |
| out_data | output | W | Scan result |
| red_valid | output | 1 | Sequence total present |
| red_data | output | W | Sequence total |

## Verification
The properties assume that `op_sel` is held constant from the first element of a sequence to its last element. The inactive-element property also assumes that `incl` does not change between two back-to-back elements. The bench changes the operator and mode only at sequence boundaries, after an element flagged as last or after a reset. Each table group therefore runs with one fixed operator and mode. Bubbles and a mid-sequence reset are exercised only in directed tests, which keep these assumptions.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_UMAX = 3'd2,
    OP_SMAX = 3'd3,
    OP_SMIN = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_COPY = 3'd7
  } scan_op_e;
endpackage

// File: rtl/seg_scan_acc.sv
// One running partial: value plus "seen" flag. An empty partial reads as identity.
module seg_scan_acc
  import seg_scan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  scan_op_e     op,
  input  logic         step,     // element accepted this cycle
  input  logic         active,
  input  logic         restart,  // empty the partial before this element (R3)
  input  logic         flush,    // empty the partial after this element (R9)
  input  logic [W-1:0] data,
  output logic [W-1:0] base_o,   // value before this element
  output logic [W-1:0] next_o    // value after this element
);
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] S_MIN   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX   = {1'b0, {(W-1){1'b1}}};

  // R5 identities
  function automatic logic [W-1:0] ident(scan_op_e o);
    case (o)
      OP_MUL:  return ONE;
      OP_SMAX: return S_MIN;
      OP_SMIN: return S_MAX;
      OP_AND:  return '1;
      default: return '0;
    endcase
  endfunction

  // R6/R7 operators; copy keeps the value already held
  function automatic logic [W-1:0] combine(scan_op_e o, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    case (o)
      OP_ADD:  r = a + b;
      OP_MUL:  r = a * b;
      OP_UMAX: r = (a > b) ? a : b;
      OP_SMAX: r = ($signed(a) > $signed(b)) ? a : b;
      OP_SMIN: r = ($signed(a) < $signed(b)) ? a : b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      default: r = a;
    endcase
    return r;
  endfunction

  logic         seen_q;
  logic [W-1:0] acc_q;
  logic         eff_seen;

  assign eff_seen = seen_q & ~restart;
  assign base_o   = eff_seen ? acc_q : ident(op);

  always_comb begin
    if (!active)       next_o = base_o;
    else if (eff_seen) next_o = combine(op, acc_q, data);
    else               next_o = data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      acc_q  <= '0;
    end else if (step) begin
      seen_q <= flush ? 1'b0 : (eff_seen | active);
      acc_q  <= next_o;
    end
  end
endmodule

// File: rtl/seg_scan_out_stage.sv
// Registered result stage: one cycle of latency for both outputs (R8, R9).
module seg_scan_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         last,
  input  logic         incl,
  input  logic [W-1:0] scan_base,
  input  logic [W-1:0] scan_next,
  input  logic [W-1:0] red_next,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         red_valid,
  output logic [W-1:0] red_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      red_valid <= 1'b0;
      red_data  <= '0;
    end else begin
      out_valid <= valid;
      red_valid <= valid & last;
      if (valid) out_data <= incl ? scan_next : scan_base;
      if (valid & last) red_data <= red_next;
    end
  end
endmodule

// File: rtl/seg_scan_unit.sv
module seg_scan_unit
  import seg_scan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_sel,
  input  logic         incl,
  input  logic         in_valid,
  input  logic         in_active,
  input  logic         in_seg_start,
  input  logic         in_last,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         red_valid,
  output logic [W-1:0] red_data
);
  scan_op_e     op;
  logic         elem_fire;
  logic         seg_restart;
  logic         seq_end;
  logic [W-1:0] seg_base, seg_next, red_base, red_next;

  assign op          = scan_op_e'(op_sel);
  assign elem_fire   = in_valid;
  assign seg_restart = in_valid & in_seg_start;
  assign seq_end     = in_valid & in_last;

  seg_scan_acc #(.W(W)) seg_acc_i (
    .clk(clk), .rst_n(rst_n), .op(op), .step(elem_fire), .active(in_active),
    .restart(seg_restart), .flush(seq_end), .data(in_data),
    .base_o(seg_base), .next_o(seg_next)
  );

  seg_scan_acc #(.W(W)) red_acc_i (
    .clk(clk), .rst_n(rst_n), .op(op), .step(elem_fire), .active(in_active),
    .restart(1'b0), .flush(seq_end), .data(in_data),
    .base_o(red_base), .next_o(red_next)
  );

  seg_scan_out_stage #(.W(W)) out_i (
    .clk(clk), .rst_n(rst_n), .valid(elem_fire), .last(in_last), .incl(incl),
    .scan_base(seg_base), .scan_next(seg_next), .red_next(red_next),
    .out_valid(out_valid), .out_data(out_data),
    .red_valid(red_valid), .red_data(red_data)
  );
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_sel,
  input logic         incl,
  input logic         in_valid,
  input logic         in_active,
  input logic         in_seg_start,
  input logic         in_last,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         red_valid,
  input logic [W-1:0] red_data
);
  p_out_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_out_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_red_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> red_valid);
  p_red_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !red_valid);
  p_seg_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_seg_start && !incl && op_sel == 3'd0) |=> out_data == '0);
  p_copy_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_active && in_seg_start && incl && op_sel == 3'd7)
      |=> out_data == $past(in_data));
  p_inactive_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_active && !in_seg_start && incl && $stable(incl) &&
     $stable(op_sel) && out_valid && !red_valid)
      |=> out_data == $past(out_data));
endmodule

bind seg_scan_unit seg_scan_chk #(.W(W)) chk_i (.*);

// File: tb/seg_scan_unit_tb_top.sv
module seg_scan_unit_tb_top;
  localparam int W = 16;
  localparam int N = 50;

  typedef struct packed {
    logic [2:0]  op;
    logic        incl;
    logic        act;
    logic        seg;
    logic        last;
    logic [15:0] data;
    logic [15:0] exp;
    logic [15:0] rexp;
    logic [3:0]  req;
  } vec_t;

  // Groups: add excl (R1), add incl (R2), mul excl (R5), umax segmented (R3),
  // inactive (R4), copy incl/excl (R7), smax/smin (R6), and/or (R5), mul wrap (R6).
  localparam vec_t VECS [N] = '{
    '{3'd0,1'b0,1'b1,1'b1,1'b0,16'd3, 16'd0, 16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b0,16'd2, 16'd3, 16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b0,16'd6, 16'd5, 16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b0,16'd4, 16'd11,16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b0,16'd5, 16'd15,16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b0,16'd11,16'd20,16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b0,16'd0, 16'd31,16'd0,4'd1},
    '{3'd0,1'b0,1'b1,1'b0,1'b1,16'd9, 16'd31,16'd40,4'd1},
    '{3'd0,1'b1,1'b1,1'b1,1'b0,16'd3, 16'd3, 16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b0,16'd2, 16'd5, 16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b0,16'd6, 16'd11,16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b0,16'd4, 16'd15,16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b0,16'd5, 16'd20,16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b0,16'd11,16'd31,16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b0,16'd0, 16'd31,16'd0,4'd2},
    '{3'd0,1'b1,1'b1,1'b0,1'b1,16'd9, 16'd40,16'd40,4'd2},
    '{3'd1,1'b0,1'b1,1'b1,1'b0,16'd3, 16'd1, 16'd0,4'd5},
    '{3'd1,1'b0,1'b1,1'b0,1'b0,16'd2, 16'd3, 16'd0,4'd5},
    '{3'd1,1'b0,1'b1,1'b0,1'b0,16'd6, 16'd6, 16'd0,4'd5},
    '{3'd1,1'b0,1'b1,1'b0,1'b1,16'd4, 16'd36,16'd144,4'd5},
    '{3'd2,1'b0,1'b1,1'b1,1'b0,16'd5, 16'd0, 16'd0,4'd3},
    '{3'd2,1'b0,1'b1,1'b0,1'b0,16'd9, 16'd5, 16'd0,4'd3},
    '{3'd2,1'b0,1'b1,1'b0,1'b0,16'd2, 16'd9, 16'd0,4'd3},
    '{3'd2,1'b0,1'b1,1'b1,1'b0,16'd4, 16'd0, 16'd0,4'd3},
    '{3'd2,1'b0,1'b1,1'b0,1'b0,16'd1, 16'd4, 16'd0,4'd3},
    '{3'd2,1'b0,1'b1,1'b0,1'b1,16'd7, 16'd4, 16'd9,4'd3},
    '{3'd0,1'b1,1'b1,1'b1,1'b0,16'd10,16'd10,16'd0,4'd4},
    '{3'd0,1'b1,1'b0,1'b0,1'b0,16'd7, 16'd10,16'd0,4'd4},
    '{3'd0,1'b1,1'b1,1'b0,1'b1,16'd5, 16'd15,16'd15,4'd4},
    '{3'd7,1'b1,1'b1,1'b1,1'b0,16'd8, 16'd8, 16'd0,4'd7},
    '{3'd7,1'b1,1'b1,1'b0,1'b0,16'd3, 16'd8, 16'd0,4'd7},
    '{3'd7,1'b1,1'b1,1'b0,1'b0,16'd4, 16'd8, 16'd0,4'd7},
    '{3'd7,1'b1,1'b1,1'b1,1'b0,16'd6, 16'd6, 16'd0,4'd7},
    '{3'd7,1'b1,1'b1,1'b0,1'b1,16'd2, 16'd6, 16'd8,4'd7},
    '{3'd7,1'b0,1'b1,1'b1,1'b0,16'd8, 16'd0, 16'd0,4'd7},
    '{3'd7,1'b0,1'b1,1'b0,1'b0,16'd3, 16'd8, 16'd0,4'd7},
    '{3'd7,1'b0,1'b1,1'b1,1'b0,16'd6, 16'd0, 16'd0,4'd7},
    '{3'd7,1'b0,1'b1,1'b0,1'b1,16'd2, 16'd6, 16'd8,4'd7},
    '{3'd3,1'b0,1'b1,1'b1,1'b0,16'hFFFE,16'h8000,16'd0,4'd6},
    '{3'd3,1'b0,1'b1,1'b0,1'b0,16'hFFFB,16'hFFFE,16'd0,4'd6},
    '{3'd3,1'b0,1'b1,1'b0,1'b1,16'h0003,16'hFFFE,16'h0003,4'd6},
    '{3'd4,1'b1,1'b1,1'b1,1'b0,16'h0002,16'h0002,16'd0,4'd6},
    '{3'd4,1'b1,1'b1,1'b0,1'b0,16'hFFF0,16'hFFF0,16'd0,4'd6},
    '{3'd4,1'b1,1'b1,1'b0,1'b1,16'h0005,16'hFFF0,16'hFFF0,4'd6},
    '{3'd5,1'b0,1'b1,1'b1,1'b0,16'h00F3,16'hFFFF,16'd0,4'd5},
    '{3'd5,1'b0,1'b1,1'b0,1'b1,16'h0035,16'h00F3,16'h0031,4'd5},
    '{3'd6,1'b1,1'b1,1'b1,1'b0,16'h0100,16'h0100,16'd0,4'd5},
    '{3'd6,1'b1,1'b1,1'b0,1'b1,16'h0003,16'h0103,16'h0103,4'd5},
    '{3'd1,1'b1,1'b1,1'b1,1'b0,16'h0100,16'h0100,16'd0,4'd6},
    '{3'd1,1'b1,1'b1,1'b0,1'b1,16'h0100,16'h0000,16'h0000,4'd6}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op_sel = '0;
  logic         incl = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_active = 1'b0;
  logic         in_seg_start = 1'b0;
  logic         in_last = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid, red_valid;
  logic [W-1:0] out_data, red_data;
  int           n_checks = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  seg_scan_unit #(.W(W)) dut_i (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic i, logic v, logic a, logic s, logic l, logic [W-1:0] d);
    op_sel = o; incl = i; in_valid = v; in_active = a;
    in_seg_start = s; in_last = l; in_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {15'd0, out_valid}, 16'd0);
    check("R10", {15'd0, red_valid}, 16'd0);
    check("R10", out_data, 16'd0);
    check("R10", red_data, 16'd0);
    rst_n = 1'b1;

    // Table walk, one element per cycle, results at the following falling edge
    drive(VECS[0].op, VECS[0].incl, 1'b1, VECS[0].act, VECS[0].seg, VECS[0].last, VECS[0].data);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      check($sformatf("R%0d", VECS[i].req), out_data, VECS[i].exp);
      check("R8", {15'd0, out_valid}, 16'd1);
      check("R9", {15'd0, red_valid}, {15'd0, VECS[i].last});
      if (VECS[i].last) check("R9", red_data, VECS[i].rexp);
      if (i + 1 < N)
        drive(VECS[i+1].op, VECS[i+1].incl, 1'b1, VECS[i+1].act, VECS[i+1].seg,
              VECS[i+1].last, VECS[i+1].data);
      else
        drive(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    end

    // R8: a bubble carries no state change
    drive(3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1);
    @(negedge clk);
    check("R2", out_data, 16'd1);
    drive(3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd99);
    @(negedge clk);
    check("R8", {15'd0, out_valid}, 16'd0);
    drive(3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd2);
    @(negedge clk);
    check("R8", out_data, 16'd3);
    check("R9", red_data, 16'd3);
    drive(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R10: reset in the middle of a sequence empties all partials
    drive(3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd5);
    @(negedge clk);
    check("R2", out_data, 16'd5);
    drive(3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", {15'd0, out_valid}, 16'd0);
    check("R10", out_data, 16'd0);
    rst_n = 1'b1;
    drive(3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd4);
    @(negedge clk);
    check("R10", out_data, 16'd4);
    check("R10", red_data, 16'd4);
    drive(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule